// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address after the TLB has missed. It accepts the miss and reads the first-level descriptor through a single request/acknowledge memory read port, then decodes it. A first-level descriptor maps a 1 MB section directly, points to a coarse or a fine second-level table, or marks the region unmapped. When it points to a table, the block makes a second read and decodes that descriptor as a large, small, extended small or tiny page.

A walk ends with a one-cycle completion pulse that carries a fault code. When there is no fault, the same cycle carries a fill strobe and a complete TLB entry. The entry holds the virtual and physical bases masked to the page size, the permission bits, the domain and the page type. The block also keeps the domain of the most recent walk that reached a domain-bearing descriptor. This lets a later fault handler report it. A mode input decides whether type-3 descriptors in coarse tables are legal.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk is at address {ttb[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor with bits[1:0]=0 ends the walk with fault=1 (section translation fault). No second read is made, there is no fill, and last_domain keeps its previous value.
- R3: A first-level descriptor with bits[1:0]=2 is a section. The walk fills with fill_type=3 and fill_perms=L1[11:0]&12'hC0C, and fill_domain=L1[8:5].
- R4: A first-level descriptor with bits[1:0]=1 is a coarse table. The second read is at {L1[31:10], va[19:12], 2'b00}. Second-level type 1 fills fill_type=2 (large) and type 2 fills fill_type=1 (small). fill_perms is L2[11:0]&12'hFFC and fill_domain is L1[8:5].
- R5: A first-level descriptor with bits[1:0]=3 is a fine table. The second read is at {L1[31:12], va[19:10], 2'b00}. Second-level type 1 gives fill_type=2 (large), type 2 gives fill_type=1 (small) and type 3 gives fill_type=5 (tiny).
- R6: A coarse second-level descriptor of type 3 gives fault=2 when ext_mode=0, and fills fill_type=4 (extended small page) when ext_mode=1.
- R7: A second-level descriptor of type 0 gives fault=2 (page translation fault). On that fault and on every successful walk, last_domain becomes L1[8:5].
- R8: The fill addresses are masked by the type. Small and extended small keep bits [31:12], large keeps [31:16], section keeps [31:20] and tiny keeps [31:10]. fill_pa comes from L1 for sections and from L2 for pages.
- R9: mem_req stays high with a stable mem_addr until mem_ack is seen, however long the acknowledge takes.
- R10: A miss is accepted only while busy is low. miss_valid pulses during a walk are ignored, and they start no later walk.
- R11: done is high for exactly one cycle per walk. fault is valid with it (0 none, 1 section, 2 page), and fill_valid is high in that cycle only when fault=0.
- R12: After reset, busy, mem_req, done and fill_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | TLB miss request |
| miss_va | input | 32 | Virtual address that missed |
| ttb | input | 32 | Translation table base |
| ext_mode | input | 1 | Permits extended small pages in coarse tables |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk complete pulse |
| fault | output | 2 | Fault code, valid with done |
| fill_valid | output | 1 | TLB write strobe |
| fill_va | output | 32 | Masked virtual base |
| fill_pa | output | 32 | Masked physical base |
| fill_perms | output | 12 | Permission bits |
| fill_domain | output | 4 | Domain |
| fill_type | output | 3 | Page type code |
| last_domain | output | 4 | Domain of last domain-bearing walk |

## Verification
The bench checks the exact read addresses for sections, coarse tables and fine tables. A design that swapped the coarse and fine index widths would read the wrong second-level word. It also checks every page type against its address mask, so that a wrong mask width would leak offset bits into the TLB. Coarse type 3 is run with the mode bit both clear and set, and an error there would allow or refuse extended pages the wrong way. A slow acknowledge and misses arriving in mid-walk show whether the request is held and whether a second walk starts by mistake. A section fault must not change last_domain, while a page fault must update it.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W   = 32;
  localparam int DOM_W  = 4;
  localparam int PERM_W = 12;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SECT = 2'd1,
    FLT_PAGE = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    PT_INVALID = 3'd0,
    PT_SMALL   = 3'd1,
    PT_LARGE   = 3'd2,
    PT_SECTION = 3'd3,
    PT_ESMALL  = 3'd4,
    PT_TINY    = 3'd5
  } ptype_e;

  function automatic logic [VA_W-1:0] type_mask(input logic [2:0] t);
    case (t)
      PT_SMALL, PT_ESMALL: type_mask = 32'hFFFF_F000;
      PT_LARGE:            type_mask = 32'hFFFF_0000;
      PT_SECTION:          type_mask = 32'hFFF0_0000;
      PT_TINY:             type_mask = 32'hFFFF_FC00;
      default:             type_mask = 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
(
  input  logic [VA_W-1:0] ttb,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] l1,
  output logic [VA_W-1:0] l1_addr,
  output logic [VA_W-1:0] l2_addr
);
  always_comb begin
    l1_addr = {ttb[31:14], va[31:20], 2'b00};
    if (l1[1:0] == 2'b01)
      l2_addr = {l1[31:10], va[19:12], 2'b00};
    else
      l2_addr = {l1[31:12], va[19:10], 2'b00};
  end
endmodule

// File: rtl/pw_entry_build.sv
module pw_entry_build
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]   va,
  input  logic [VA_W-1:0]   l1,
  input  logic [VA_W-1:0]   l2,
  input  logic              ext,
  output logic [2:0]        ptype,
  output logic [VA_W-1:0]   e_va,
  output logic [VA_W-1:0]   e_pa,
  output logic [PERM_W-1:0] perms,
  output logic [DOM_W-1:0]  dom
);
  logic            is_sect;
  logic [VA_W-1:0] mask;

  always_comb begin
    is_sect = (l1[1:0] == 2'b10);
    case (l1[1:0])
      2'b10: ptype = PT_SECTION;
      2'b01: begin
        case (l2[1:0])
          2'b01:   ptype = PT_LARGE;
          2'b10:   ptype = PT_SMALL;
          2'b11:   ptype = ext ? PT_ESMALL : PT_INVALID;
          default: ptype = PT_INVALID;
        endcase
      end
      2'b11: begin
        case (l2[1:0])
          2'b01:   ptype = PT_LARGE;
          2'b10:   ptype = PT_SMALL;
          2'b11:   ptype = PT_TINY;
          default: ptype = PT_INVALID;
        endcase
      end
      default: ptype = PT_INVALID;
    endcase
    mask  = type_mask(ptype);
    e_va  = va & mask;
    e_pa  = (is_sect ? l1 : l2) & mask;
    perms = is_sect ? (l1[PERM_W-1:0] & 12'hC0C) : (l2[PERM_W-1:0] & 12'hFFC);
    dom   = l1[8:5];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [31:0]       miss_va,
  input  logic [31:0]       ttb,
  input  logic              ext_mode,
  output logic              busy,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [1:0]        fault,
  output logic              fill_valid,
  output logic [31:0]       fill_va,
  output logic [31:0]       fill_pa,
  output logic [11:0]       fill_perms,
  output logic [3:0]        fill_domain,
  output logic [2:0]        fill_type,
  output logic [3:0]        last_domain
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_RESP} state_e;

  state_e          state_q, state_d;
  logic [VA_W-1:0] va_q, ttb_q, l1_q, l2_q;
  logic            ext_q;
  logic [DOM_W-1:0] ldom_q;
  logic            accept, cap_l1, cap_l2, ldom_en;
  logic [VA_W-1:0] l1_addr, l2_addr;
  logic [2:0]      ptype;
  fault_e          fault_c;

  pw_addr_gen u_addr (
    .ttb(ttb_q), .va(va_q), .l1(l1_q),
    .l1_addr(l1_addr), .l2_addr(l2_addr)
  );

  pw_entry_build u_entry (
    .va(va_q), .l1(l1_q), .l2(l2_q), .ext(ext_q),
    .ptype(ptype), .e_va(fill_va), .e_pa(fill_pa),
    .perms(fill_perms), .dom(fill_domain)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    cap_l1  = 1'b0;
    cap_l2  = 1'b0;
    case (state_q)
      S_IDLE: if (miss_valid) begin
        accept  = 1'b1;
        state_d = S_L1;
      end
      S_L1: if (mem_ack) begin
        cap_l1 = 1'b1;
        if (mem_rdata[1:0] == 2'b00 || mem_rdata[1:0] == 2'b10)
          state_d = S_RESP;
        else
          state_d = S_L2;
      end
      S_L2: if (mem_ack) begin
        cap_l2  = 1'b1;
        state_d = S_RESP;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    if (l1_q[1:0] == 2'b00)       fault_c = FLT_SECT;
    else if (ptype == PT_INVALID) fault_c = FLT_PAGE;
    else                          fault_c = FLT_NONE;
    ldom_en = (state_q == S_RESP) && (fault_c != FLT_SECT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      ttb_q <= '0;
      ext_q <= 1'b0;
    end else if (accept) begin
      va_q  <= miss_va;
      ttb_q <= ttb;
      ext_q <= ext_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      l1_q <= '0;
    else if (cap_l1) l1_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      l2_q <= '0;
    else if (cap_l2) l2_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ldom_q <= '0;
    else if (ldom_en) ldom_q <= l1_q[8:5];
  end

  // outputs
  assign busy        = (state_q != S_IDLE);
  assign mem_req     = (state_q == S_L1) || (state_q == S_L2);
  assign mem_addr    = (state_q == S_L2) ? l2_addr : l1_addr;
  assign done        = (state_q == S_RESP);
  assign fault       = done ? fault_c : FLT_NONE;
  assign fill_valid  = done && (fault_c == FLT_NONE);
  assign fill_type   = ptype;
  assign last_domain = ldom_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  assert_fill_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (((fill_va | fill_pa) & ~type_mask(fill_type)) == 32'h0
                    && fill_type != 3'd0));

  assert_l1_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept) |=> (mem_req && mem_addr[1:0] == 2'b00));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk, rst_n;
  logic        miss_valid, ext_mode, mem_ack;
  logic [31:0] miss_va, ttb, mem_rdata;
  logic        busy, mem_req, done, fill_valid;
  logic [31:0] mem_addr, fill_va, fill_pa;
  logic [1:0]  fault;
  logic [11:0] fill_perms;
  logic [3:0]  fill_domain, last_domain;
  logic [2:0]  fill_type;

  int errors = 0, checks = 0;
  int delay = 0, cnt = 0, nrd = 0, base = 0;
  logic [31:0] l1d, l2d;
  logic [31:0] rd_log [0:63];
  logic [31:0] g_va, g_pa;
  logic [11:0] g_perms;
  logic [3:0]  g_dom;
  logic [2:0]  g_type;
  logic [1:0]  g_fault;
  logic        g_fill;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
    .ttb(ttb), .ext_mode(ext_mode), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fill_valid(fill_valid), .fill_va(fill_va),
    .fill_pa(fill_pa), .fill_perms(fill_perms), .fill_domain(fill_domain),
    .fill_type(fill_type), .last_domain(last_domain)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (cnt >= delay) begin
          mem_ack   <= 1'b1;
          mem_rdata <= (nrd == base) ? l1d : l2d;
          rd_log[nrd % 64] <= mem_addr;
          nrd <= nrd + 1;
          cnt <= 0;
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] tb_,
                      input logic ext, input logic [31:0] a1,
                      input logic [31:0] a2, input int dly, input bit jam);
    bit seen = 0;
    l1d = a1; l2d = a2; delay = dly; base = nrd;
    @(negedge clk);
    miss_va = va; ttb = tb_; ext_mode = ext; miss_valid = 1'b1;
    @(negedge clk);
    if (jam) begin
      miss_va = ~va; ttb = ~tb_;
    end else miss_valid = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (done) begin
        seen = 1;
        g_va = fill_va; g_pa = fill_pa; g_perms = fill_perms;
        g_dom = fill_domain; g_type = fill_type; g_fault = fault;
        g_fill = fill_valid;
      end
      @(negedge clk);
    end
    miss_valid = 1'b0;
    chk("R11", "done seen", {31'd0, seen}, 32'd1);
    chk("R11", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12", "busy", {31'd0, busy}, 32'd0);
    chk("R12", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R12", "done", {31'd0, done}, 32'd0);
    chk("R12", "fill_valid", {31'd0, fill_valid}, 32'd0);
  endtask

  task automatic t_section;
    walk(32'hABC1_2345, 32'h1234_5678, 1'b0, 32'h8765_41E6, 32'h0, 0, 0);
    chk("R1", "l1 addr", rd_log[base % 64], 32'h1234_6AF0);
    chk("R3", "reads", nrd - base, 1);
    chk("R3", "fault", {30'd0, g_fault}, 0);
    chk("R11", "fill", {31'd0, g_fill}, 1);
    chk("R3", "type", {29'd0, g_type}, 3);
    chk("R3", "perms", {20'd0, g_perms}, 32'h004);
    chk("R3", "domain", {28'd0, g_dom}, 32'hF);
    chk("R8", "sect pa", g_pa, 32'h8760_0000);
    chk("R8", "sect va", g_va, 32'hABC0_0000);
    chk("R7", "last_domain", {28'd0, last_domain}, 32'hF);
  endtask

  task automatic t_l1_fault;
    walk(32'h0034_5678, 32'h0, 1'b0, 32'h0000_0FF0, 32'h0, 0, 0);
    chk("R2", "fault", {30'd0, g_fault}, 1);
    chk("R2", "no fill", {31'd0, g_fill}, 0);
    chk("R2", "reads", nrd - base, 1);
    chk("R2", "last_domain kept", {28'd0, last_domain}, 32'hF);
  endtask

  task automatic t_coarse_large;
    walk(32'h0034_5678, 32'h0, 1'b0, 32'h5555_5421, 32'h9ABC_DEF1, 0, 0);
    chk("R1", "l1 addr", rd_log[base % 64], 32'h0000_000C);
    chk("R4", "l2 addr", rd_log[(base + 1) % 64], 32'h5555_5514);
    chk("R4", "type large", {29'd0, g_type}, 2);
    chk("R4", "perms", {20'd0, g_perms}, 32'hEF0);
    chk("R4", "domain", {28'd0, g_dom}, 1);
    chk("R8", "large pa", g_pa, 32'h9ABC_0000);
    chk("R8", "large va", g_va, 32'h0034_0000);
    chk("R7", "last_domain", {28'd0, last_domain}, 1);
  endtask

  task automatic t_coarse_small_slow;
    walk(32'h0034_5678, 32'h0, 1'b0, 32'h5555_5421, 32'h1357_9BDE, 3, 0);
    chk("R9", "reads", nrd - base, 2);
    chk("R9", "l2 addr held", rd_log[(base + 1) % 64], 32'h5555_5514);
    chk("R4", "type small", {29'd0, g_type}, 1);
    chk("R8", "small pa", g_pa, 32'h1357_9000);
    chk("R8", "small va", g_va, 32'h0034_5000);
    chk("R4", "perms", {20'd0, g_perms}, 32'hBDC);
  endtask

  task automatic t_coarse_t3;
    walk(32'h0034_5678, 32'h0, 1'b0, 32'h5555_5421, 32'h0000_0FFF, 0, 0);
    chk("R6", "ext off fault", {30'd0, g_fault}, 2);
    chk("R6", "ext off no fill", {31'd0, g_fill}, 0);
    walk(32'h0034_5678, 32'h0, 1'b1, 32'h5555_5421, 32'h2468_ACEF, 0, 0);
    chk("R6", "ext on fault", {30'd0, g_fault}, 0);
    chk("R6", "ext on type", {29'd0, g_type}, 4);
    chk("R8", "esmall pa", g_pa, 32'h2468_A000);
    chk("R6", "perms", {20'd0, g_perms}, 32'hCEC);
  endtask

  task automatic t_fine;
    walk(32'hFEDC_BA98, 32'hFFFF_C000, 1'b0, 32'h1111_20A3, 32'h8765_43F7, 0, 0);
    chk("R1", "l1 addr", rd_log[base % 64], 32'hFFFF_FFB4);
    chk("R5", "l2 addr", rd_log[(base + 1) % 64], 32'h1111_2CB8);
    chk("R5", "type tiny", {29'd0, g_type}, 5);
    chk("R8", "tiny pa", g_pa, 32'h8765_4000);
    chk("R8", "tiny va", g_va, 32'hFEDC_B800);
    chk("R5", "perms", {20'd0, g_perms}, 32'h3F4);
    chk("R5", "domain", {28'd0, g_dom}, 5);
    walk(32'hFEDC_BA98, 32'hFFFF_C000, 1'b0, 32'h1111_20A3, 32'h0F0F_0F0D, 0, 0);
    chk("R5", "type large", {29'd0, g_type}, 2);
    chk("R8", "fine large va", g_va, 32'hFEDC_0000);
    chk("R8", "fine large pa", g_pa, 32'h0F0F_0000);
  endtask

  task automatic t_page_fault;
    walk(32'h0034_5678, 32'h0, 1'b0, 32'h5555_5421, 32'h9ABC_DEF1, 0, 0);
    walk(32'hFEDC_BA98, 32'hFFFF_C000, 1'b0, 32'h1111_20A3, 32'h1234_5670, 0, 0);
    chk("R7", "fault", {30'd0, g_fault}, 2);
    chk("R7", "no fill", {31'd0, g_fill}, 0);
    chk("R7", "last_domain", {28'd0, last_domain}, 5);
  endtask

  task automatic t_busy_ignore;
    walk(32'hABC1_2345, 32'h1234_5678, 1'b0, 32'h8765_41E6, 32'h0, 4, 1);
    chk("R10", "first va kept", g_va, 32'hABC0_0000);
    chk("R10", "l1 addr from first", rd_log[base % 64], 32'h1234_6AF0);
    repeat (5) @(negedge clk);
    chk("R10", "no later walk", {31'd0, busy}, 0);
    chk("R10", "reads", nrd - base, 1);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_va = '0; ttb = '0; ext_mode = 1'b0;
    l1d = '0; l2d = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_section;
    t_l1_fault;
    t_coarse_large;
    t_coarse_small_slow;
    t_coarse_t3;
    t_fine;
    t_page_fault;
    t_busy_ignore;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule